// File: doc/BRIEF.md
# Text-mode character video generator

This block turns a small screen buffer of character cells into a serial pixel stream for a text display. The screen is 16 cells wide and 10 cells tall. Each cell shows one of 64 glyphs, 8 pixels wide and 8 pixel rows tall, and carries a 2-bit grey level. That grey level feeds an external level converter. External timing logic supplies a line-start strobe and a frame-start strobe at the pixel clock, plus a blanking input. Software or a host fills the buffer through a simple write port.

On every line start a state machine moves through four states: `ST_IDLE`, `ST_FETCH`, `ST_LOAD` and `ST_ACTIVE`. Its transitions are:
- idle to fetch, on a line start that falls inside the 80 active scan lines;
- fetch to load, after one cycle;
- load to active, after one cycle;
- active to active, while pixels remain on the line;
- active to idle, after the last pixel of column 15;
- any state to fetch (or to idle), on a new line start, which restarts the line at once.

In `ST_FETCH` the cell code for column 0 is read. In `ST_LOAD` the glyph row is looked up and placed in the shift register. During `ST_ACTIVE` the register shifts one pixel per clock. The next cell is read one pixel before the current character ends, so there is no gap between characters. The glyph table is addressed with the pixel row within the cell as the high part and the character code as the low part.

Top module: `txtvid_gen`

## Requirements
- R1: While reset is asserted, and after it until the first displayed pixel, `pix_o` = 0, `grey_o` = 0 and `dark_o` = 1.
- R2: A buffer entry holds the character code in bits 5:0 and the grey level in bits 7:6. The entry for column c of character row r sits at address r*16 + c.
- R3: The glyph row for code k at pixel row s is the byte ((k << 2) ^ s ^ (s << 5)) mod 256. Its bit 7 is sent first, one bit per clock. Pixel 0 of column 0 appears in the third clock after the edge that samples `line_start`. The clock before that one is dark.
- R4: `grey_o` equals bits 7:6 of the entry for the character being shown. It is held for all 8 pixels of that character and can change only at a character boundary.
- R5: Line index 0 is the first `line_start` after `frame_start`, and each later `line_start` adds one. The character row is the line index divided by 8, and the pixel row within the cell is the line index modulo 8.
- R6: While `blank_i` is 1, `pix_o` = 0, `grey_o` = 0 and `dark_o` = 1 in the same cycle.
- R7: Lines with index 80 or above are dark for their whole length.
- R8: After the 128th pixel of a line, the outputs stay dark until the next line start.
- R9: A `line_start` in the middle of a line drops the rest of that line. The next line then begins at column 0 with the usual 2-clock latency.
- R10: When `frame_start` and `line_start` arrive in the same cycle, that line is line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel (dot) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe: the next line start is line 0 |
| line_start | input | 1 | One-cycle strobe that begins a scan line |
| blank_i | input | 1 | Forces the outputs dark while high |
| wr_en | input | 1 | Screen buffer write enable |
| wr_addr | input | 8 | Screen buffer write address (cells 0 to 159) |
| wr_data | input | 8 | Buffer entry: grey in bits 7:6, code in bits 5:0 |
| pix_o | output | 1 | Serial pixel stream |
| grey_o | output | 2 | Grey level of the character being shown |
| dark_o | output | 1 | High when no pixel is being displayed |

## Verification
Each kind of internal fault shows at the ports in a distinct way:
- A wrong bit or column counter shifts the glyph pattern across cells, and the pixel-by-pixel comparison of a line catches it within one character.
- A fault in the line counter picks the wrong glyph row or character row, which shows on the first line whose content differs.
- A stale state after the last column, or a missed restart, leaves pixels on the line tail or on the line that follows a restart.

The stimulus fills the buffer with random entries plus edge entries (code 63, grey 3, the last cell) and sweeps whole frames with random blanking. This makes each of these faults visible within a single scan line.

// File: rtl/txtvid_pkg.sv
package txtvid_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_LOAD   = 2'd2,
        ST_ACTIVE = 2'd3
    } vstate_t;

endpackage

// File: rtl/txtvid_cellram.sv
module txtvid_cellram #(
    parameter int DEPTH  = 160,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            cells[wr_addr] <= wr_data;
        end
    end

    // registered read port, one cycle of latency
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= cells[rd_addr];
        end
    end

endmodule

// File: rtl/txtvid_glyphrom.sv
module txtvid_glyphrom #(
    parameter int CODE_W = 6,
    parameter int SCAN_W = 3,
    parameter int CELL_W = 8
) (
    // pixel row in the high part, character code in the low part
    input  logic [SCAN_W+CODE_W-1:0] addr,
    output logic [CELL_W-1:0]        pattern
);

    logic [CODE_W-1:0] code;
    logic [SCAN_W-1:0] scan;

    always_comb begin
        code    = addr[CODE_W-1:0];
        scan    = addr[SCAN_W+CODE_W-1:CODE_W];
        pattern = (CELL_W'(code) << 2)
                ^ CELL_W'(scan)
                ^ (CELL_W'(scan) << (CELL_W - SCAN_W));
    end

endmodule

// File: rtl/txtvid_shifter.sv
module txtvid_shifter #(
    parameter int CELL_W = 8,
    parameter int GREY_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              shift,
    input  logic [CELL_W-1:0] pat_in,
    input  logic [GREY_W-1:0] grey_in,
    output logic              msb_o,
    output logic [GREY_W-1:0] grey_q
);

    logic [CELL_W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg   <= '0;
            grey_q <= '0;
        end else if (load) begin
            sreg   <= pat_in;
            grey_q <= grey_in;
        end else if (shift) begin
            sreg   <= {sreg[CELL_W-2:0], 1'b0};
        end
    end

    assign msb_o = sreg[CELL_W-1];

endmodule

// File: rtl/txtvid_gen.sv
module txtvid_gen
    import txtvid_pkg::*;
#(
    parameter int COLS   = 16,
    parameter int ROWS   = 10,
    parameter int CELL_W = 8,
    parameter int CELL_H = 8,
    parameter int CODE_W = 6,
    parameter int GREY_W = 2,
    localparam int CELLS  = COLS * ROWS,
    localparam int ADDR_W = $clog2(CELLS),
    localparam int DATA_W = CODE_W + GREY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              line_start,
    input  logic              blank_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pix_o,
    output logic [GREY_W-1:0] grey_o,
    output logic              dark_o
);

    localparam int COL_W  = $clog2(COLS);
    localparam int BIT_W  = $clog2(CELL_W);
    localparam int SCAN_W = $clog2(CELL_H);
    localparam int LINES  = ROWS * CELL_H;
    localparam int LINE_W = $clog2(LINES) + 1;
    localparam int ROW_W  = LINE_W - SCAN_W;

    vstate_t           state, state_nxt;
    logic [COL_W-1:0]  col_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic [LINE_W-1:0] cur_line, next_line, base_line;
    logic              start_ok, last_bit, last_col;

    logic              rd_en, sh_load, sh_shift, live;
    logic [COL_W-1:0]  rd_col;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic [ROW_W-1:0]  row_idx;
    logic [SCAN_W-1:0] scan_idx;
    logic [CELL_W-1:0] glyph_row;
    logic              sh_msb;
    logic [GREY_W-1:0] sh_grey;

    always_comb begin
        base_line = frame_start ? '0 : next_line;
        start_ok  = line_start && (int'(base_line) < LINES);
        last_bit  = (bit_cnt == BIT_W'(CELL_W - 1));
        last_col  = (col_cnt == COL_W'(COLS - 1));
        row_idx   = cur_line[LINE_W-1:SCAN_W];
        scan_idx  = cur_line[SCAN_W-1:0];
    end

    // scan line tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_line  <= LINE_W'(LINES);
            next_line <= '0;
        end else if (line_start) begin
            cur_line  <= base_line;
            next_line <= (&base_line) ? base_line : base_line + 1'b1;
        end else if (frame_start) begin
            next_line <= '0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        if (line_start) begin
            state_nxt = start_ok ? ST_FETCH : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   state_nxt = ST_IDLE;
                ST_FETCH:  state_nxt = ST_LOAD;
                ST_LOAD:   state_nxt = ST_ACTIVE;
                ST_ACTIVE: state_nxt = (last_bit && last_col) ? ST_IDLE : ST_ACTIVE;
            endcase
        end
    end

    // column and pixel counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_cnt <= '0;
            bit_cnt <= '0;
        end else if (line_start) begin
            col_cnt <= '0;
            bit_cnt <= '0;
        end else if (state == ST_ACTIVE) begin
            if (last_bit) begin
                bit_cnt <= '0;
                if (!last_col) begin
                    col_cnt <= col_cnt + 1'b1;
                end
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // control and output decode
    always_comb begin
        rd_en    = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        rd_col   = col_cnt;
        live     = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_FETCH: begin
                rd_en = 1'b1;
            end
            ST_LOAD: begin
                sh_load = 1'b1;
            end
            ST_ACTIVE: begin
                live   = !blank_i;
                rd_col = col_cnt + 1'b1;
                // prefetch the next cell one pixel ahead of the boundary
                rd_en  = (bit_cnt == BIT_W'(CELL_W - 2)) && !last_col;
                if (last_bit && !last_col) begin
                    sh_load = 1'b1;
                end else begin
                    sh_shift = 1'b1;
                end
            end
        endcase
        rd_addr = ADDR_W'(int'(row_idx) * COLS + int'(rd_col));
        pix_o   = live & sh_msb;
        grey_o  = live ? sh_grey : '0;
        dark_o  = !live;
    end

    txtvid_cellram #(
        .DEPTH  (CELLS),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_ram (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    txtvid_glyphrom #(
        .CODE_W (CODE_W),
        .SCAN_W (SCAN_W),
        .CELL_W (CELL_W)
    ) u_rom (
        .addr    ({scan_idx, rd_data[CODE_W-1:0]}),
        .pattern (glyph_row)
    );

    txtvid_shifter #(
        .CELL_W (CELL_W),
        .GREY_W (GREY_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .shift   (sh_shift),
        .pat_in  (glyph_row),
        .grey_in (rd_data[DATA_W-1:CODE_W]),
        .msb_o   (sh_msb),
        .grey_q  (sh_grey)
    );

endmodule

// File: rtl/txtvid_chk.sv
module txtvid_chk
    import txtvid_pkg::*;
#(
    parameter int COLS   = 16,
    parameter int ROWS   = 10,
    parameter int CELL_W = 8,
    parameter int CELL_H = 8,
    parameter int GREY_W = 2,
    localparam int COL_W  = $clog2(COLS),
    localparam int BIT_W  = $clog2(CELL_W),
    localparam int LINES  = ROWS * CELL_H,
    localparam int LINE_W = $clog2(LINES) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_start,
    input logic              blank_i,
    input logic              pix_o,
    input logic [GREY_W-1:0] grey_o,
    input logic              dark_o,
    input vstate_t           state,
    input logic [COL_W-1:0]  col_cnt,
    input logic [BIT_W-1:0]  bit_cnt,
    input logic [LINE_W-1:0] cur_line
);

    // R1
    rst_dark_chk: assert property (@(posedge clk)
        !rst_n |=> (dark_o && !pix_o && grey_o == '0));

    // R6
    blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |-> (dark_o && !pix_o && grey_o == '0));

    // R4
    grey_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dark_o && !$past(dark_o) && grey_o != $past(grey_o)) |-> (bit_cnt == '0));

    // R8
    line_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && col_cnt == COL_W'(COLS - 1)
         && bit_cnt == BIT_W'(CELL_W - 1) && !line_start) |=> dark_o);

    // R7
    outside_area_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cur_line) >= LINES) |-> dark_o);

    // R3
    first_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && !line_start) |=> (dark_o == blank_i));

endmodule

bind txtvid_gen txtvid_chk #(
    .COLS   (COLS),
    .ROWS   (ROWS),
    .CELL_W (CELL_W),
    .CELL_H (CELL_H),
    .GREY_W (GREY_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .blank_i    (blank_i),
    .pix_o      (pix_o),
    .grey_o     (grey_o),
    .dark_o     (dark_o),
    .state      (state),
    .col_cnt    (col_cnt),
    .bit_cnt    (bit_cnt),
    .cur_line   (cur_line)
);

// File: tb/sim_txtvid_gen.sv
`timescale 1ns/1ps
module sim_txtvid_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       line_start = 1'b0;
    logic       blank_i = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       pix_o;
    logic [1:0] grey_o;
    logic       dark_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] shadow [160];

    always #2 clk = ~clk;

    txtvid_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_start  (line_start),
        .blank_i     (blank_i),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .pix_o       (pix_o),
        .grey_o      (grey_o),
        .dark_o      (dark_o)
    );

    // R3 glyph formula
    function automatic logic [7:0] glyph(input logic [5:0] code, input logic [2:0] sc);
        return {code, 2'b00} ^ {5'b0, sc} ^ {sc, 5'b0};
    endfunction

    // packed {dark, grey, pix} expected for one pixel slot
    function automatic logic [3:0] expect_px(input int line, input int p, input bit blk);
        logic [7:0] ent;
        logic [7:0] pat;
        if (blk || line >= 80) return 4'b1000;
        ent = shadow[(line / 8) * 16 + p / 8];          // R2 R5
        pat = glyph(ent[5:0], 3'(line % 8));
        return {1'b0, ent[7:6], pat[7 - (p % 8)]};       // R4
    endfunction

    task automatic check(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {dark_o, grey_o, pix_o};
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b (dark,grey,pix) t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cell(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
        shadow[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_line(input int exp_line, input int blank_pct, input int npix, input bit with_frame);
        bit blk;
        @(negedge clk);
        line_start = 1'b1; frame_start = with_frame;
        @(negedge clk);
        line_start = 1'b0; frame_start = 1'b0;
        @(negedge clk); #1;
        check("R3 latency", 4'b1000);
        for (int p = 0; p < npix; p++) begin
            @(negedge clk);
            blk = (int'($urandom % 100) < blank_pct);
            blank_i = blk;
            #1;
            if (blk)                check("R6", expect_px(exp_line, p, blk));
            else if (exp_line >= 80) check("R7", expect_px(exp_line, p, blk));
            else                    check("R2 R3 R4 R5", expect_px(exp_line, p, blk));
        end
        blank_i = 1'b0;
        if (npix == 128) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk); #1;
                check("R8", 4'b1000);
            end
        end
    endtask

    task automatic run_frame(input int blank_pct);
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        for (int l = 0; l < 82; l++) begin
            run_line(l, blank_pct, 128, 1'b0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #1;
        check("R1 in reset", 4'b1000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check("R1 after reset", 4'b1000);

        for (int a = 0; a < 160; a++) write_cell(a, 8'($urandom));
        write_cell(0,   8'hFF);
        write_cell(15,  8'h40);
        write_cell(16,  8'h80);
        write_cell(159, 8'hBF);
        run_frame(0);

        for (int a = 0; a < 160; a++) write_cell(a, 8'($urandom));
        run_frame(15);

        // R10: frame and line start together give line 0
        run_line(0, 0, 128, 1'b1);
        // R9: restart mid-line, next line starts at column 0
        run_line(1, 0, 37, 1'b0);
        run_line(2, 0, 128, 1'b0);
        run_line(9, 0, 0, 1'b1) ;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule